// File: doc/BRIEF.md
# Synchronous Bus Transfer Controller

This block moves single words between a user-side command port and a small register array over a clocked parallel bus. The address and data lines are separate, and the bus is controlled by an address-enable line, a read strobe and a write strobe. Every bus event happens on the rising clock edge, and each clock period is one bus cycle. The bus master must first win the bus: it raises a request line and waits for an external grant. It then runs a fixed three-cycle transfer. The matching target answers by reading from or writing to its register array.

A user issues one command at a time. The command is a read/write flag, an address and, for writes, a data word. The command is accepted only while the master is idle. The master returns a one-cycle done pulse, and for a read the fetched word. If the grant does not arrive within `GNT_TIMEOUT` cycles, the command is dropped and a one-cycle error pulse is raised.

The master state machine has these states:
- `ST_IDLE`: ready for a command.
- `ST_REQ`: bus request raised, waiting for grant.
- `ST_ADDR`: first bus cycle, address and address-enable driven.
- `ST_CMD`: second cycle. A read strobe for reads, or write data driven for writes.
- `ST_DATA`: third cycle. The target drives read data, or the write strobe is raised and the target captures the data.
- `ST_DONE`: done pulse.
- `ST_ABORT`: error pulse.

The transitions are:
- idle→req on an accepted command.
- req→addr when grant is seen.
- req→abort when the wait limit is reached without a grant.
- addr→cmd→data→done unconditionally.
- done→idle and abort→idle unconditionally.

Top module: `sbx_top`

## Requirements
- R1: After reset the master is in ST_IDLE. In that state `cmd_ready` is 1 and `bus_req`, `bus_ale`, `bus_rd`, `bus_wr`, `bus_data`, `tgt_drive`, `rsp_done` and `rsp_err` are all 0.
- R2: `cmd_ready` is 1 only in ST_IDLE. A command is latched when `cmd_valid` is 1 at a rising edge in ST_IDLE. `cmd_valid` and the command fields at any other time have no effect on the bus or on the results.
- R3: `bus_req` is 1 from the cycle after acceptance through ST_DATA. ST_ADDR begins the cycle after the first edge at which `bus_gnt` is sampled 1. `bus_ale` is never 1 without `bus_req`.
- R4: In ST_ADDR, ST_CMD and ST_DATA, `bus_ale` is 1 and `bus_addr` carries the latched address.
- R5: For a read, `bus_rd` is 1 for exactly one cycle (ST_CMD). The target drives `bus_data` with the addressed word, with `tgt_drive` at 1, in the following cycle (ST_DATA) only.
- R6: For a write, the master drives the word on `bus_data` in ST_CMD and ST_DATA. `bus_wr` is 1 only in ST_DATA. The target stores the word at the edge that ends ST_DATA.
- R7: The cycle after ST_DATA, `rsp_done` is 1 for one cycle. For a read, `rsp_rdata` then holds the word sampled at the end of ST_DATA. In that cycle `bus_req`, `bus_ale` and both strobes are 0, and the next cycle is ST_IDLE.
- R8: The target drives data only while `bus_ale` is 1 in a read data cycle. It never drives during a write or when idle. At most one side drives, and `bus_data` is 0 when neither does.
- R9: If `bus_gnt` is still 0 at the GNT_TIMEOUT-th edge in ST_REQ, the master enters ST_ABORT. There `rsp_err` is 1 for one cycle, `bus_req` is 0, no strobe or address-enable is raised and no data is stored, and the master then returns to ST_IDLE. A grant seen at that last edge still starts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | User command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write word |
| cmd_ready | output | 1 | Master idle and accepting |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read result |
| rsp_err | output | 1 | One-cycle grant-timeout pulse |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_ale | output | 1 | Address-enable line |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Address lines |
| bus_data | output | DW | Data lines as resolved between master and target |
| tgt_drive | output | 1 | Target is driving the data lines |

## Verification
The assertions take it that the arbiter keeps `bus_gnt` high for as long as `bus_req` stays high once it has granted the bus. They also take it that the grant drops when the request falls. The bench models the arbiter as a counter that raises grant a chosen number of cycles after it sees the request and clears it when the request goes low. That delay is varied from zero up to one past the timeout limit, and a never-granting case is included. Commands are driven half a cycle away from the sampling edge. Stray `cmd_valid` pulses are injected mid-transfer to confirm they are ignored.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_CMD   = 3'd3,
        ST_DATA  = 3'd4,
        ST_DONE  = 3'd5,
        ST_ABORT = 3'd6
    } sbx_state_e;
endpackage

// File: rtl/sbx_regfile.sv
module sbx_regfile #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                words[g] <= wdata;
            end
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/sbx_target.sv
module sbx_target #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          oe
);
    logic          store_en;
    logic [DW-1:0] array_q;
    logic          oe_q;
    logic [DW-1:0] dout_q;

    // capture only in a selected write cycle
    assign store_en = ale && wr;

    sbx_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_en),
        .waddr (addr),
        .wdata (din),
        .raddr (addr),
        .rdata (array_q)
    );

    // read strobe seen this cycle -> drive the word in the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            oe_q   <= ale && rd && !wr;
            dout_q <= (ale && rd) ? array_q : '0;
        end
    end

    assign oe   = oe_q;
    assign dout = dout_q;

    p_drive_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> $past(ale && rd));
    p_no_drive_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (ale && !wr));
endmodule

// File: rtl/sbx_master.sv
module sbx_master
    import sbx_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DW          = 16,
    parameter int GNT_TIMEOUT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] m_data,
    output logic          m_oe,
    input  logic [DW-1:0] bus_din
);
    localparam int CW = $clog2(GNT_TIMEOUT + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(GNT_TIMEOUT - 1);

    sbx_state_e    state, state_nx;
    logic          op_write;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_wdata;
    logic [CW-1:0] wait_cnt;
    logic [DW-1:0] rdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = ST_REQ;
            ST_REQ: begin
                if (bus_gnt)                    state_nx = ST_ADDR;
                else if (wait_cnt == WAIT_LAST) state_nx = ST_ABORT;
            end
            ST_ADDR:  state_nx = ST_CMD;
            ST_CMD:   state_nx = ST_DATA;
            ST_DATA:  state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            ST_ABORT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // command latch, wait counter, read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
            wait_cnt <= '0;
            rdata_q  <= '0;
        end else begin
            if (state == ST_IDLE) begin
                wait_cnt <= '0;
                if (cmd_valid) begin
                    op_write <= cmd_write;
                    op_addr  <= cmd_addr;
                    op_wdata <= cmd_wdata;
                end
            end
            if (state == ST_REQ && !bus_gnt) wait_cnt <= wait_cnt + 1'b1;
            if (state == ST_DATA && !op_write) rdata_q <= bus_din;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        rsp_done  = 1'b0;
        rsp_err   = 1'b0;
        bus_req   = 1'b0;
        bus_ale   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        m_oe      = 1'b0;
        unique case (state)
            ST_IDLE:  cmd_ready = 1'b1;
            ST_REQ:   bus_req   = 1'b1;
            ST_ADDR: begin
                bus_req = 1'b1;
                bus_ale = 1'b1;
            end
            ST_CMD: begin
                bus_req = 1'b1;
                bus_ale = 1'b1;
                bus_rd  = !op_write;
                m_oe    = op_write;
            end
            ST_DATA: begin
                bus_req = 1'b1;
                bus_ale = 1'b1;
                bus_wr  = op_write;
                m_oe    = op_write;
            end
            ST_DONE:  rsp_done = 1'b1;
            ST_ABORT: rsp_err  = 1'b1;
            default:  cmd_ready = 1'b0;
        endcase
    end

    assign bus_addr  = bus_ale ? op_addr : '0;
    assign m_data    = m_oe ? op_wdata : '0;
    assign rsp_rdata = rdata_q;

    p_ale_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> bus_req);
    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(bus_req || rsp_done || rsp_err));
    p_rd_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_ale && $past(bus_ale)));
    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);
    p_wr_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (m_oe && $past(m_oe) && $stable(m_data)));
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && cmd_ready));
    p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !(bus_req || bus_ale || bus_rd || bus_wr));
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> (!rsp_err && cmd_ready));
    p_err_after_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_err) |-> ($past(bus_req) && !bus_req && !bus_ale));
endmodule

// File: rtl/sbx_top.sv
module sbx_top #(
    parameter int AW          = 4,
    parameter int DW          = 16,
    parameter int GNT_TIMEOUT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic          tgt_drive
);
    logic [DW-1:0] m_data;
    logic          m_oe;
    logic [DW-1:0] t_data;
    logic          t_oe;

    sbx_master #(.AW(AW), .DW(DW), .GNT_TIMEOUT(GNT_TIMEOUT)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_ale   (bus_ale),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .m_data    (m_data),
        .m_oe      (m_oe),
        .bus_din   (bus_data)
    );

    sbx_target #(.AW(AW), .DW(DW)) u_target (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (bus_ale),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .din   (bus_data),
        .dout  (t_data),
        .oe    (t_oe)
    );

    // resolved data lines: whichever side drives, else zero
    always_comb begin
        if (m_oe)      bus_data = m_data;
        else if (t_oe) bus_data = t_data;
        else           bus_data = '0;
    end

    assign tgt_drive = t_oe;

    p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_oe && t_oe));
endmodule

// File: tb/sbx_top_tb.sv
`timescale 1ns/1ps
module sbx_top_tb;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int TO = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready, rsp_done, rsp_err, bus_req, bus_ale, bus_rd, bus_wr, tgt_drive;
    logic [DW-1:0] rsp_rdata, bus_data;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 1'b0;

    int tests = 0;
    int fails = 0;
    int gnt_delay = 0;
    int req_age = 0;
    bit chk_en = 0;

    // behavioural model
    int mph = 0;
    bit mw = 0;
    int maddr = 0, mwd = 0, mwcnt = 0, mrdata = 0;
    int mem [DEPTH];

    always #2 clk = ~clk;

    sbx_top #(.AW(AW), .DW(DW), .GNT_TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_ale(bus_ale), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data), .tgt_drive(tgt_drive)
    );

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // arbiter stand-in: grant gnt_delay cycles after request, never if negative
    always @(negedge clk) begin
        if (!bus_req) begin
            req_age = 0;
            bus_gnt = 1'b0;
        end else begin
            req_age++;
            bus_gnt = (gnt_delay >= 0) && (req_age > gnt_delay);
        end
    end

    // reference model advances on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mwcnt = 0; mrdata = 0;
            for (int i = 0; i < DEPTH; i++) mem[i] = 0;
        end else begin
            case (mph)
                0: if (cmd_valid) begin
                       mw = cmd_write; maddr = int'(cmd_addr); mwd = int'(cmd_wdata);
                       mwcnt = 0; mph = 1;
                   end
                1: if (bus_gnt) mph = 2;
                   else if (mwcnt == TO - 1) mph = 6;
                   else mwcnt++;
                2: mph = 3;
                3: mph = 4;
                4: begin
                       if (mw) mem[maddr] = mwd; else mrdata = mem[maddr];
                       mph = 5;
                   end
                default: mph = 0;
            endcase
        end
    end

    // compare on every cycle, away from the edge
    always @(negedge clk) begin
        if (chk_en) begin
            int exp_data;
            exp_data = 0;
            if (mw && (mph == 3 || mph == 4)) exp_data = mwd;
            else if (!mw && mph == 4) exp_data = mem[maddr];
            check("R2", "cmd_ready", int'(cmd_ready), int'(mph == 0));
            check("R3", "bus_req", int'(bus_req), int'(mph >= 1 && mph <= 4));
            check("R4", "bus_ale", int'(bus_ale), int'(mph >= 2 && mph <= 4));
            if (mph >= 2 && mph <= 4) check("R4", "bus_addr", int'(bus_addr), maddr);
            check("R5", "bus_rd", int'(bus_rd), int'(!mw && mph == 3));
            check("R6", "bus_wr", int'(bus_wr), int'(mw && mph == 4));
            check("R8", "bus_data", int'(bus_data), exp_data);
            check("R8", "tgt_drive", int'(tgt_drive), int'(!mw && mph == 4));
            check("R7", "rsp_done", int'(rsp_done), int'(mph == 5));
            if (mph == 5 && !mw) check("R7", "rsp_rdata", int'(rsp_rdata), mrdata);
            check("R9", "rsp_err", int'(rsp_err), int'(mph == 6));
        end
    end

    // issue one command; optionally inject a stray command mid-transfer
    task automatic run_cmd(bit w, int a, int d, int dly, bit stray);
        gnt_delay = dly;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w;
        cmd_addr = AW'(a); cmd_wdata = DW'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_wdata = '0;
        if (stray) begin
            @(negedge clk);
            @(negedge clk);
            cmd_valid = 1'b1; cmd_write = 1'b1;
            cmd_addr = AW'(a); cmd_wdata = 16'hFFFF;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!(rsp_done || rsp_err)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_expect(string req, int a, int exp);
        run_cmd(1'b0, a, 0, 0, 1'b0);
        // the done cycle has passed; rdata is held
        check(req, "read-back", int'(rsp_rdata), exp);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "ready", int'(cmd_ready), 1);
        check("R1", "bus lines", int'({bus_req, bus_ale, bus_rd, bus_wr, tgt_drive}), 0);
        check("R1", "bus_data", int'(bus_data), 0);
        check("R1", "pulses", int'({rsp_done, rsp_err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1;
        // R6/R5: write then read back, immediate grant
        run_cmd(1'b1, 3, 16'hA5A5, 0, 1'b0);
        read_expect("R6", 3, 16'hA5A5);
        read_expect("R5", 0, 0);
        // R3: delayed grant
        run_cmd(1'b1, 15, 16'h1234, 2, 1'b0);
        run_cmd(1'b0, 15, 0, 3, 1'b0);
        check("R3", "delayed-grant read", int'(rsp_rdata), 16'h1234);
        // R2: stray command during a transfer is ignored
        run_cmd(1'b0, 3, 0, 1, 1'b1);
        check("R2", "stray ignored rdata", int'(rsp_rdata), 16'hA5A5);
        read_expect("R2", 3, 16'hA5A5);
        // R9: grant on last allowed cycle proceeds
        run_cmd(1'b1, 7, 16'h0F0F, TO - 1, 1'b0);
        read_expect("R9", 7, 16'h0F0F);
        // R9: grant one cycle too late aborts, nothing stored
        run_cmd(1'b1, 5, 16'hBEEF, TO, 1'b0);
        read_expect("R9", 5, 0);
        // R9: grant never comes
        run_cmd(1'b1, 5, 16'hCAFE, -1, 1'b0);
        read_expect("R9", 5, 0);
        // R4/R7: sweep every address
        for (int i = 0; i < DEPTH; i++) run_cmd(1'b1, i, (i * 16'h0111) ^ 16'h5A00, i % 3, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            run_cmd(1'b0, i, 0, (i + 1) % 4, 1'b0);
            check("R7", "sweep read", int'(rsp_rdata), ((i * 16'h0111) ^ 16'h5A00) & 16'hFFFF);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual hung expected finished");
            end
        join_any
        chk_en = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule